// File: doc/BRIEF.md
# Four-Lane Quintet Dealer

This block takes the octets of one frame at a time and repacks their bits into 5-bit quintets. The quintets are handed out in a fixed rotation over four parallel transmit lanes. The first quintet of a frame goes to lane 0, the next to lane 1, and so on, wrapping back to lane 0 after lane 3. Each lane's share of the frame is bracketed by a start strobe and an end strobe, and all four lanes see these strobes in the same cycle. The lane streams are meant to feed per-lane scramblers and 5B6B coders further down the transmit path. For that reason every lane output is exactly five bits wide and carries its own valid flag.

**Input stream.** The input is a valid/ready octet stream with start-of-frame and end-of-frame flags.

- Bits are taken least-significant first from each octet and appended to a residue register.
- A quintet is emitted whenever at least five bits are pending. At most one quintet is emitted per clock, so the input is throttled through `in_ready`.
- An octet is transferred in a cycle where both `in_valid` and `in_ready` are high. The source must hold `in_data`, `in_sof` and `in_eof` stable while `in_valid` is high and `in_ready` is low.

**Back-pressure rules.**

- Inside a frame, `in_ready` is low whenever the residue left after this cycle's emission, plus eight new bits, would exceed the residue capacity.
- Between frames, `in_ready` equals the inverse of `in_sof`. Stray octets are taken and dropped. An octet that opens a frame is held off until the start strobe has gone out.
- `in_ready` stays low from the acceptance of the end-of-frame octet until the end strobe has been issued.

**End of frame.** At the end of a frame, a partial last quintet is filled with zeros. Whole zero quintets are then added until the last quintet of the frame lands on lane 3, so every lane carries the same number of quintets.

Top module: `quint_splitter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the lane valids and both strobe buses are low one cycle later. The residue and the lane pointer are cleared, so the first quintet after reset goes to lane 0.
- R2: Bit i of the frame sits at bit (i mod 5) of quintet floor(i/5). Frame bit i is bit (i mod 8) of octet floor(i/8), so packing is least-significant bit first.
- R3: Quintet k of a frame appears on lane k mod 4, in bits [5*lane+4 : 5*lane] of `lane_quint`. No more than one lane valid is high in any cycle.
- R4: Once per frame, all four bits of `lane_sod` rise together. This happens in a cycle with no lane valid and before the frame's first quintet.
- R5: When 8·N is not a multiple of 5 for an N-octet frame, the quintet holding the final data bits has its unused upper bits at zero.
- R6: A frame of N octets yields exactly 4·ceil(ceil(8N/5)/4) quintets. The ones after the last data-bearing quintet are all zero.
- R7: All four bits of `lane_eod` rise together, once per frame. This happens in the cycle right after the frame's final quintet (which is on lane 3), with no lane valid.
- R8: `in_ready` is low from the cycle after the end-of-frame octet is taken until the end strobe. Residue occupancy never exceeds `RES_BITS`.
- R9: Between frames, an octet with `in_sof` low is accepted in the cycle it is offered. It produces no lane output and no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Octet on `in_data` is offered |
| in_ready | output | 1 | Octet is taken at this edge if offered |
| in_data | input | OW (8) | Frame octet |
| in_sof | input | 1 | Offered octet is the first of a frame |
| in_eof | input | 1 | Offered octet is the last of a frame |
| lane_valid | output | LANES (4) | One bit per lane: quintet present this cycle |
| lane_quint | output | LANES*QW (20) | Quintets, lane g in bits [5g+4:5g] |
| lane_sod | output | LANES (4) | Start strobe per lane |
| lane_eod | output | LANES (4) | End strobe per lane |

## Verification
Octet acceptance and quintet emission fall in the same cycle: the residue drops five bits while eight bits arrive. The end-of-frame octet is usually taken in a cycle where a quintet also leaves. The bench provokes both by streaming frames of 1 to 12 octets with `in_valid` held high, which drives the residue through every fill level up to its capacity. It repeats the sweep with idle gaps. It judges the overlap by rebuilding the bit string from the lane outputs and comparing it with the frame, and by checking the quintet count and where the end strobe sits.

// File: rtl/quint_pkg.sv
package quint_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_DRAIN,
    ST_CLOSE
  } frm_state_e;
endpackage

// File: rtl/quint_packer.sv
// Residue register: appends octets LSB first, releases the low QW bits on emit.
module quint_packer #(
  parameter int OW       = 8,
  parameter int QW       = 5,
  parameter int RES_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [OW-1:0]                 octet,
  input  logic                          emit,
  input  logic                          drain,
  output logic [QW-1:0]                 quint,
  output logic [$clog2(RES_BITS+1)-1:0] fill,
  output logic                          have_quint,
  output logic                          last_piece,
  output logic                          room
);
  localparam int FW = $clog2(RES_BITS + 1);

  logic [RES_BITS-1:0] res_q;
  logic [RES_BITS-1:0] res_shifted;
  logic [RES_BITS-1:0] res_d;
  logic [RES_BITS-1:0] octet_wide;
  logic [FW:0]         fill_ext;
  logic [FW:0]         after_emit;
  logic [FW:0]         fill_d;

  assign fill_ext   = {1'b0, fill};
  assign have_quint = fill_ext >= (FW+1)'(QW);
  assign last_piece = fill_ext <= (FW+1)'(QW);

  // occupancy once this cycle's quintet has left (partial piece flushes to zero)
  always_comb begin
    if (!emit)                     after_emit = fill_ext;
    else if (drain && !have_quint) after_emit = '0;
    else                           after_emit = fill_ext - (FW+1)'(QW);
  end

  assign room        = (after_emit + (FW+1)'(OW)) <= (FW+1)'(RES_BITS);
  assign res_shifted = emit ? (res_q >> QW) : res_q;
  assign octet_wide  = {{(RES_BITS-OW){1'b0}}, octet};
  assign res_d       = take ? (res_shifted | (octet_wide << after_emit)) : res_shifted;
  assign fill_d      = take ? (after_emit + (FW+1)'(OW)) : after_emit;
  assign quint       = res_q[QW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      fill  <= '0;
    end else begin
      res_q <= res_d;
      fill  <= fill_d[FW-1:0];
    end
  end
endmodule

// File: rtl/quint_framer.sv
// Frame sequencer: start strobe, data phase, padded drain, end strobe.
module quint_framer
  import quint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  input  logic have_quint,
  input  logic last_piece,
  input  logic room,
  input  logic ptr_last,
  output logic in_ready,
  output logic take,
  output logic emit,
  output logic drain,
  output logic open_pulse,
  output logic close_pulse
);
  frm_state_e st_q, st_d;

  assign emit        = ((st_q == ST_DATA) && have_quint) || (st_q == ST_DRAIN);
  assign drain       = (st_q == ST_DRAIN);
  assign open_pulse  = (st_q == ST_OPEN);
  assign close_pulse = (st_q == ST_CLOSE);
  assign take        = (st_q == ST_DATA) && in_valid && room;

  always_comb begin
    case (st_q)
      ST_IDLE: in_ready = !in_sof;
      ST_DATA: in_ready = room;
      default: in_ready = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (in_valid && in_sof) st_d = ST_OPEN;
      ST_OPEN:  st_d = ST_DATA;
      ST_DATA:  if (take && in_eof) st_d = ST_DRAIN;
      ST_DRAIN: if (last_piece && ptr_last) st_d = ST_CLOSE;
      ST_CLOSE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/quint_dealer.sv
// Round-robin lane pointer and registered per-lane outputs.
module quint_dealer #(
  parameter int LANES = 4,
  parameter int QW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  emit,
  input  logic [QW-1:0]         quint,
  input  logic                  open_pulse,
  input  logic                  close_pulse,
  output logic                  ptr_last,
  output logic [LANES-1:0]      lane_valid,
  output logic [LANES*QW-1:0]   lane_quint,
  output logic [LANES-1:0]      lane_sod,
  output logic [LANES-1:0]      lane_eod
);
  localparam int PW = $clog2(LANES);

  logic [PW-1:0] ptr_q;
  logic          sod_r;
  logic          eod_r;

  assign ptr_last = (ptr_q == PW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sod_r <= 1'b0;
      eod_r <= 1'b0;
    end else begin
      sod_r <= open_pulse;
      eod_r <= close_pulse;
      if (open_pulse)    ptr_q <= '0;
      else if (emit)     ptr_q <= ptr_last ? '0 : ptr_q + 1'b1;
    end
  end

  assign lane_sod = {LANES{sod_r}};
  assign lane_eod = {LANES{eod_r}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          v_r;
    logic [QW-1:0] d_r;
    logic          hit;
    assign hit = emit && (ptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        d_r <= '0;
      end else begin
        v_r <= hit;
        if (hit) d_r <= quint;
      end
    end
    assign lane_valid[g]         = v_r;
    assign lane_quint[g*QW +: QW] = d_r;
  end
endmodule

// File: rtl/quint_splitter.sv
module quint_splitter #(
  parameter int LANES    = 4,
  parameter int QW       = 5,
  parameter int OW       = 8,
  parameter int RES_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OW-1:0]         in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  output logic [LANES-1:0]      lane_valid,
  output logic [LANES*QW-1:0]   lane_quint,
  output logic [LANES-1:0]      lane_sod,
  output logic [LANES-1:0]      lane_eod
);
  localparam int FW = $clog2(RES_BITS + 1);

  logic          take, emit, drain, open_pulse, close_pulse;
  logic          have_quint, last_piece, room, ptr_last;
  logic [QW-1:0] quint;
  logic [FW-1:0] fill_bits;

  quint_packer #(.OW(OW), .QW(QW), .RES_BITS(RES_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .octet(in_data), .emit(emit),
    .drain(drain), .quint(quint), .fill(fill_bits), .have_quint(have_quint),
    .last_piece(last_piece), .room(room)
  );

  quint_framer u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .have_quint(have_quint), .last_piece(last_piece),
    .room(room), .ptr_last(ptr_last), .in_ready(in_ready), .take(take),
    .emit(emit), .drain(drain), .open_pulse(open_pulse),
    .close_pulse(close_pulse)
  );

  quint_dealer #(.LANES(LANES), .QW(QW)) u_deal (
    .clk(clk), .rst_n(rst_n), .emit(emit), .quint(quint),
    .open_pulse(open_pulse), .close_pulse(close_pulse), .ptr_last(ptr_last),
    .lane_valid(lane_valid), .lane_quint(lane_quint), .lane_sod(lane_sod),
    .lane_eod(lane_eod)
  );
endmodule

// File: rtl/quint_split_chk.sv
module quint_split_chk #(
  parameter int LANES    = 4,
  parameter int RES_BITS = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [LANES-1:0]              lane_valid,
  input logic [LANES-1:0]              lane_sod,
  input logic [LANES-1:0]              lane_eod,
  input logic [$clog2(RES_BITS+1)-1:0] fill
);
  localparam int PW = $clog2(LANES);

  logic [PW-1:0] exp_lane;

  always_ff @(posedge clk) begin
    if (!rst_n)           exp_lane <= '0;
    else if (|lane_valid) exp_lane <= (exp_lane == PW'(LANES - 1)) ? '0 : exp_lane + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (lane_valid == '0 && lane_sod == '0 && lane_eod == '0));

  // R3
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_valid));

  // R3
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_valid) |-> lane_valid[exp_lane]);

  // R4
  sod_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_sod) |-> (&lane_sod && lane_valid == '0));

  // R7
  eod_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_eod) |-> (&lane_eod && lane_valid == '0));

  // R7
  eod_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_eod) |-> $past(lane_valid[LANES-1]));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= RES_BITS);
endmodule

bind quint_splitter quint_split_chk #(.LANES(LANES), .RES_BITS(RES_BITS)) u_split_chk (
  .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_sod(lane_sod),
  .lane_eod(lane_eod), .fill(fill_bits)
);

// File: tb/test_quint_splitter.sv
module test_quint_splitter;
  localparam int  LANES    = 4;
  localparam int  QW       = 5;
  localparam int  OW       = 8;
  localparam int  RES_BITS = 12;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [OW-1:0] in_data = '0;
  logic in_ready;
  logic [LANES-1:0] lane_valid, lane_sod, lane_eod;
  logic [LANES*QW-1:0] lane_quint;

  always #(CLK_PERIOD/2) clk = ~clk;

  quint_splitter #(.LANES(LANES), .QW(QW), .OW(OW), .RES_BITS(RES_BITS)) i_quint_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .lane_valid(lane_valid), .lane_quint(lane_quint),
    .lane_sod(lane_sod), .lane_eod(lane_eod)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [OW-1:0] fr [0:15];
  logic [QW-1:0] q_data [0:63];
  int q_lane [0:63];
  int q_cyc  [0:63];
  int qn, sod_cnt, sod_cyc, eod_cnt, eod_cyc;
  bit sod_part, eod_part, multi_lane, drain_bad, drain_mark;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_capture();
    qn = 0; sod_cnt = 0; eod_cnt = 0; sod_cyc = 0; eod_cyc = 0;
    sod_part = 0; eod_part = 0; multi_lane = 0; drain_bad = 0; drain_mark = 0;
  endtask

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin : mon
    int hits;
    int li;
    if (rst_n) begin
      hits = 0; li = 0;
      for (int i = 0; i < LANES; i++) if (lane_valid[i]) begin hits++; li = i; end
      if (hits > 1) multi_lane = 1;
      if (hits > 0 && qn < 64) begin
        q_data[qn] = lane_quint[li*QW +: QW]; q_lane[qn] = li; q_cyc[qn] = cyc; qn++;
      end
      if (|lane_sod) begin
        sod_cnt++; sod_cyc = cyc;
        if (lane_sod != '1 || hits != 0) sod_part = 1;
      end
      if (|lane_eod) begin
        eod_cnt++; eod_cyc = cyc; drain_mark = 0;
        if (lane_eod != '1 || hits != 0) eod_part = 1;
      end else if (drain_mark && in_ready) drain_bad = 1;
    end
  end

  task automatic send_byte(input logic [OW-1:0] d, input bit s, input bit e, output int waits);
    waits = 0; in_data = d; in_sof = s; in_eof = e; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    if (e) drain_mark = 1;
  endtask

  function automatic logic [QW-1:0] exp_quint(input int k, input int n);
    logic [QW-1:0] r;
    for (int b = 0; b < QW; b++) begin
      int idx = k*QW + b;
      r[b] = (idx < OW*n) ? fr[idx/OW][idx%OW] : 1'b0;
    end
    return r;
  endfunction

  task automatic check_frame(input int n);
    int nd = (OW*n + QW - 1) / QW;
    int tot = ((nd + LANES - 1) / LANES) * LANES;
    int full = (OW*n) / QW;
    int bad_k = -1;
    int lane_bad = -1;
    chk(qn == tot, "R6", "quintet count", qn, tot);
    for (int k = 0; k < qn && k < 64; k++) if (lane_bad < 0 && q_lane[k] != k % LANES) lane_bad = k;
    chk(lane_bad < 0 && !multi_lane, "R3", "lane of quintet",
        (lane_bad < 0) ? 0 : q_lane[lane_bad], (lane_bad < 0) ? 0 : lane_bad % LANES);
    for (int k = 0; k < full && k < qn; k++) if (bad_k < 0 && q_data[k] != exp_quint(k, n)) bad_k = k;
    chk(bad_k < 0, "R2", "data quintet", (bad_k < 0) ? 0 : int'(q_data[bad_k]),
        (bad_k < 0) ? 0 : int'(exp_quint(bad_k, n)));
    if (full != nd && full < qn)
      chk(q_data[full] == exp_quint(full, n), "R5", "partial quintet",
          int'(q_data[full]), int'(exp_quint(full, n)));
    bad_k = -1;
    for (int k = nd; k < qn; k++) if (bad_k < 0 && q_data[k] != '0) bad_k = k;
    chk(bad_k < 0, "R6", "pad quintet value", (bad_k < 0) ? 0 : int'(q_data[bad_k]), 0);
    chk(sod_cnt == 1 && !sod_part && qn > 0 && sod_cyc < q_cyc[0], "R4", "start strobe count", sod_cnt, 1);
    chk(eod_cnt == 1 && !eod_part && qn > 0 && eod_cyc == q_cyc[qn-1] + 1, "R7",
        "end strobe cycle", eod_cyc, (qn > 0) ? q_cyc[qn-1] + 1 : 0);
    chk(!drain_bad, "R8", "in_ready high during drain", int'(drain_bad), 0);
  endtask

  task automatic run_frame(input int n, input int pat, input bit gaps, input int junk);
    int w;
    logic [7:0] lcg = 8'(n * 29 + 7);
    clear_capture();
    for (int j = 0; j < junk; j++) begin
      send_byte(OW'(8'hA5 ^ 8'(j)), 1'b0, 1'b0, w);
      chk(w == 0, "R9", "stray octet wait cycles", w, 0);
    end
    if (junk > 0) begin
      @(negedge clk);
      chk(qn == 0 && sod_cnt == 0 && eod_cnt == 0, "R9", "output after stray octets", qn + sod_cnt + eod_cnt, 0);
    end
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: fr[k] = OW'(k * 37 + n);
        1: fr[k] = '1;
        default: begin lcg = lcg * 8'd93 + 8'd41; fr[k] = OW'(lcg); end
      endcase
    end
    for (int k = 0; k < n; k++) begin
      send_byte(fr[k], k == 0, k == n - 1, w);
      if (gaps && (k % 2 == 0)) begin @(posedge clk); #1; end
    end
    while (eod_cnt == 0) @(negedge clk);
    @(negedge clk);
    check_frame(n);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL R7 watchdog: actual hung expected end of run");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int w;
    clear_capture();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(lane_valid == '0, "R1", "lane_valid in reset", int'(lane_valid), 0);
    chk(lane_sod == '0 && lane_eod == '0, "R1", "strobes in reset", int'({lane_sod, lane_eod}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int pat = 0; pat < 3; pat++)
      for (int n = 1; n <= 12; n++)
        run_frame(n, pat, pat == 2, (n % 4 == 1) ? 2 : 0);

    // reset in the middle of a frame
    clear_capture();
    send_byte(8'h3C, 1'b1, 1'b0, w);
    send_byte(8'hC3, 1'b0, 1'b0, w);
    send_byte(8'h5A, 1'b0, 1'b0, w);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(lane_valid == '0 && lane_sod == '0 && lane_eod == '0, "R1", "outputs after mid-frame reset",
        int'({lane_valid, lane_sod, lane_eod}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    run_frame(3, 0, 1'b0, 0);
    chk(qn > 0 && q_lane[0] == 0, "R1", "first lane after reset", (qn > 0) ? q_lane[0] : -1, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule